// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a clocked single-port memory organised as four 9-bit byte lanes (36 bits per word) with a parameterized number of words. It behaves like a cache-style pipelined burst SRAM. Address and control are registered on every rising clock edge. A burst is opened by either of two address strobes: one meant for a processor and one for a cache controller. After that, a 2-bit counter inside the block forms the low two address bits. The counter moves on when the advance input is low, so each burst covers an aligned group of four words. A static mode input selects linear or interleaved order within the group.

Writes can cover the full word through a global write strobe, or selected byte lanes through a byte-write strobe combined with one enable per lane. Reads go through an output register. The tri-state data bus is modelled as a registered data-out vector plus a drive flag. The drive flag is gated at once by an asynchronous output enable. Three chip selects form the device enable. A device that is being selected needs two clock edges before it drives the bus, while a device that is being deselected stops driving after one edge. This lets two devices share a bus without contention. A sleep input stops all new accesses and silences the output.

All control inputs are active low except `sel1`, `sleep` and `interleave`.

Top module: `pbsram`

## Requirements
- R1: A cycle with `ctrl_strobe_n` low (and no accepted processor strobe) loads `addr` as the burst base and clears the burst counter. It is a write if the write controls select any lane, otherwise a read.
- R2: With `interleave` low, the low two address bits of the access are (base low bits + count) mod 4. The upper address bits keep the base value.
- R3: With `interleave` high, the low two address bits of the access are base low bits XOR count.
- R4: In a cycle with no strobe and `adv_n` low, the counter steps by one before the access. With `adv_n` high, the same word is accessed again: read if no write is requested, written otherwise.
- R5: While `sel0_n` is high, `proc_strobe_n` is ignored and the cycle acts as a burst continuation. `ctrl_strobe_n` is not gated by `sel0_n`.
- R6: The first cycle of a burst opened by an accepted processor strobe is always a read, whatever the write controls are.
- R7: `gwrite_n` low writes all 36 bits, whatever `bwrite_n` and `lane_we_n` are.
- R8: With `gwrite_n` high, lane i (bits 9i+8 down to 9i, where lane_we_n[0] selects bits 8:0) is written only when `bwrite_n` and `lane_we_n[i]` are both low. No lane is written while `bwrite_n` is high.
- R9: Read data appears on `rdata`, and `drive` rises, after the clock edge that follows the edge on which the read was captured.
- R10: A strobe accepted with the device enable false (enable true only for `sel0_n`=0, `sel1`=1, `sel2_n`=0) deselects the device. `drive` then falls at that same edge and stays low until a later selected read. A newly selected read drives the bus no earlier than the second edge.
- R11: `oe_n` high forces `drive` low at once, without a clock edge, and `oe_n` low restores it.
- R12: In a cycle with `sleep` high, no access is started, the burst counter and base are held, and `drive` is low after that edge.
- R13: During and right after reset, `drive` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, sampled on a strobe |
| proc_strobe_n | input | 1 | Processor burst-start strobe, active low |
| ctrl_strobe_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| gwrite_n | input | 1 | Global (full word) write, active low |
| bwrite_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| drive | output | 1 | High when the block would drive the data bus |

## Verification
On every cycle, the bound checker watches the burst counter and base address. It checks that the counter clears on a start, holds without advance and steps by one with it. It checks that the base is untouched while a processor strobe comes with `sel0_n` high, and that an accepted processor start always produces a read. It also checks that sleep and deselect cycles leave the output stage silent. Only the bench scenarios can show which word is actually returned: linear and interleaved wrap orders, byte-lane merges, global-write override, the two-edge read latency, the two-edge enable against one-edge disable, and the combinational effect of `oe_n`.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

   // Access recorded by the input register stage for the array stage.
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   // Width of the in-burst counter: a burst always spans four words.
   localparam int unsigned CNT_W = 2;

endpackage

// File: rtl/pbsram_ctrl.sv
// Input register stage: strobe decode, chip-select capture, burst counter
// and write-mask formation.
module pbsram_ctrl
   import pbsram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned DATA_W = LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic               proc_strobe_n,
   input  logic               ctrl_strobe_n,
   input  logic               adv_n,
   input  logic               sel0_n,
   input  logic               sel1,
   input  logic               sel2_n,
   input  logic               gwrite_n,
   input  logic               bwrite_n,
   input  logic [LANES-1:0]   lane_we_n,
   input  logic               sleep,
   input  logic [DATA_W-1:0]  wdata,
   output logic [ADDR_W-1:0]  base_q,
   output logic [CNT_W-1:0]   cnt_q,
   output logic               sel_q,
   output op_e                op_q,
   output logic [LANES-1:0]   mask_q,
   output logic [DATA_W-1:0]  wdata_q,
   output logic               kill
);

   logic              chip_on;
   logic              proc_go;
   logic              ctrl_go;
   logic              start;
   logic [LANES-1:0]  mask_in;
   logic              wr_any;

   logic [ADDR_W-1:0] base_d;
   logic [CNT_W-1:0]  cnt_d;
   logic              sel_d;
   op_e               op_d;

   assign chip_on = !sel0_n && sel1 && !sel2_n;
   assign proc_go = !proc_strobe_n && !sel0_n && !sleep;
   assign ctrl_go = !ctrl_strobe_n && !sleep && !proc_go;
   assign start   = proc_go || ctrl_go;

   // Global write covers every lane; otherwise the byte qualifier and the
   // lane's own enable must both be low.
   for (genvar i = 0; i < LANES; i++) begin : g_mask
      assign mask_in[i] = !gwrite_n || (!bwrite_n && !lane_we_n[i]);
   end
   assign wr_any = |mask_in;

   // A deselecting start or a sleep cycle silences the output at this edge.
   assign kill = sleep || (start && !chip_on);

   always_comb begin
      base_d = base_q;
      cnt_d  = cnt_q;
      sel_d  = sel_q;
      op_d   = OP_NONE;
      if (sleep) begin
         op_d = OP_NONE;
      end else if (start) begin
         base_d = addr;
         cnt_d  = '0;
         sel_d  = chip_on;
         if (!chip_on) begin
            op_d = OP_NONE;
         end else if (proc_go) begin
            op_d = OP_READ;
         end else if (wr_any) begin
            op_d = OP_WRITE;
         end else begin
            op_d = OP_READ;
         end
      end else if (sel_q) begin
         if (!adv_n) begin
            cnt_d = cnt_q + 1'b1;
         end
         op_d = wr_any ? OP_WRITE : OP_READ;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         sel_q  <= 1'b0;
         op_q   <= OP_NONE;
         mask_q <= '0;
      end else begin
         base_q <= base_d;
         cnt_q  <= cnt_d;
         sel_q  <= sel_d;
         op_q   <= op_d;
         mask_q <= (op_d == OP_WRITE) ? mask_in : '0;
      end
   end

   always_ff @(posedge clk) begin
      wdata_q <= wdata;
   end

endmodule

// File: rtl/pbsram_burst.sv
// Forms the word address of the current access from the burst base and the
// in-burst count, in linear or interleaved order.
module pbsram_burst
   import pbsram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              interleave,
   output logic [ADDR_W-1:0] word_addr
);

   logic [CNT_W-1:0] lo_lin;
   logic [CNT_W-1:0] lo_ilv;
   logic [CNT_W-1:0] lo;

   assign lo_lin = base[CNT_W-1:0] + cnt;
   assign lo_ilv = base[CNT_W-1:0] ^ cnt;
   assign lo     = interleave ? lo_ilv : lo_lin;

   if (ADDR_W > CNT_W) begin : g_upper
      assign word_addr = {base[ADDR_W-1:CNT_W], lo};
   end else begin : g_only_low
      assign word_addr = lo;
   end

endmodule

// File: rtl/pbsram_array.sv
// Storage split into byte lanes, plus the output register and its drive flag.
module pbsram_array
   import pbsram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned DATA_W = LANES * LANE_W,
   localparam int unsigned DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] word_addr,
   input  op_e               op_q,
   input  logic [LANES-1:0]  mask_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic              kill,
   output logic [DATA_W-1:0] dout_q,
   output logic              out_vld
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (op_q == OP_WRITE && mask_q[i]) begin
            mem[word_addr] <= wdata_q[i*LANE_W +: LANE_W];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout_q[i*LANE_W +: LANE_W] <= '0;
         end else if (op_q == OP_READ) begin
            dout_q[i*LANE_W +: LANE_W] <= mem[word_addr];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
      end else begin
         out_vld <= (op_q == OP_READ) && !kill;
      end
   end

endmodule

// File: rtl/pbsram.sv
module pbsram
   import pbsram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9,
   localparam int unsigned DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              proc_strobe_n,
   input  logic              ctrl_strobe_n,
   input  logic              adv_n,
   input  logic              sel0_n,
   input  logic              sel1,
   input  logic              sel2_n,
   input  logic              gwrite_n,
   input  logic              bwrite_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic              interleave,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              drive
);

   if (ADDR_W <= CNT_W) begin : g_bad_addr
      $error("pbsram: ADDR_W must exceed the burst counter width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("pbsram: LANES and LANE_W must be at least 1");
   end

   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              sel_q;
   op_e               op_q;
   logic [LANES-1:0]  mask_q;
   logic [DATA_W-1:0] wdata_q;
   logic              kill;
   logic [ADDR_W-1:0] word_addr;
   logic              out_vld;

   pbsram_ctrl #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) i_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .addr          (addr),
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .adv_n         (adv_n),
      .sel0_n        (sel0_n),
      .sel1          (sel1),
      .sel2_n        (sel2_n),
      .gwrite_n      (gwrite_n),
      .bwrite_n      (bwrite_n),
      .lane_we_n     (lane_we_n),
      .sleep         (sleep),
      .wdata         (wdata),
      .base_q        (base_q),
      .cnt_q         (cnt_q),
      .sel_q         (sel_q),
      .op_q          (op_q),
      .mask_q        (mask_q),
      .wdata_q       (wdata_q),
      .kill          (kill)
   );

   pbsram_burst #(
      .ADDR_W (ADDR_W)
   ) i_burst (
      .base       (base_q),
      .cnt        (cnt_q),
      .interleave (interleave),
      .word_addr  (word_addr)
   );

   pbsram_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) i_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_addr (word_addr),
      .op_q      (op_q),
      .mask_q    (mask_q),
      .wdata_q   (wdata_q),
      .kill      (kill),
      .dout_q    (rdata),
      .out_vld   (out_vld)
   );

   assign drive = out_vld && !oe_n;

endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk
   import pbsram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep,
   input logic              proc_strobe_n,
   input logic              ctrl_strobe_n,
   input logic              adv_n,
   input logic              sel0_n,
   input logic              sel1,
   input logic              sel2_n,
   input logic [ADDR_W-1:0] base_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              sel_q,
   input op_e               op_q,
   input logic              out_vld
);

   logic no_strobe;
   logic chip_on;
   assign no_strobe = ctrl_strobe_n && (proc_strobe_n || sel0_n);
   assign chip_on   = !sel0_n && sel1 && !sel2_n;

   AST_START_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_strobe_n && !sleep) |=> (cnt_q == '0)); // R1

   AST_HOLD_WITHOUT_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !sleep && no_strobe && adv_n) |=> $stable(cnt_q)); // R4

   AST_STEP_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && !sleep && no_strobe && !adv_n) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R4

   AST_PROC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && sel0_n && ctrl_strobe_n && !sleep) |=> $stable(base_q)); // R5

   AST_PROC_READS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && chip_on && !sleep) |=> (op_q == OP_READ)); // R6

   AST_DESELECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !no_strobe && !chip_on) |=> !out_vld); // R10

   AST_SLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!out_vld && op_q == OP_NONE && $stable(cnt_q) && $stable(base_q))); // R12

endmodule

bind pbsram pbsram_chk #(
   .ADDR_W (ADDR_W)
) i_pbsram_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sleep         (sleep),
   .proc_strobe_n (proc_strobe_n),
   .ctrl_strobe_n (ctrl_strobe_n),
   .adv_n         (adv_n),
   .sel0_n        (sel0_n),
   .sel1          (sel1),
   .sel2_n        (sel2_n),
   .base_q        (base_q),
   .cnt_q         (cnt_q),
   .sel_q         (sel_q),
   .op_q          (op_q),
   .out_vld       (out_vld)
);

// File: tb/test_pbsram.sv
module test_pbsram;

   localparam int AW = 6;
   localparam int DW = 36;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          proc_strobe_n = 1'b1;
   logic          ctrl_strobe_n = 1'b1;
   logic          adv_n = 1'b1;
   logic          sel0_n = 1'b0;
   logic          sel1 = 1'b1;
   logic          sel2_n = 1'b0;
   logic          gwrite_n = 1'b1;
   logic          bwrite_n = 1'b1;
   logic [3:0]    lane_we_n = 4'hF;
   logic          oe_n = 1'b0;
   logic          sleep = 1'b0;
   logic          interleave = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pbsram i_pbsram (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
      .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .gwrite_n(gwrite_n), .bwrite_n(bwrite_n), .lane_we_n(lane_we_n),
      .oe_n(oe_n), .sleep(sleep), .interleave(interleave),
      .wdata(wdata), .rdata(rdata), .drive(drive)
   );

   // p c a s0 s1 s2 gw bw lanes ilv addr wdata | exp_drive exp_rdata req
   typedef struct packed {
      logic          p, c, a, s0, s1, s2, gw, bw;
      logic [3:0]    ln;
      logic          il;
      logic [AW-1:0] ad;
      logic [DW-1:0] wd;
      logic          dv;
      logic [DW-1:0] rd;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 31;
   localparam vec_t VEC [NV] = '{
      // R1 R7: controller-started full-word write burst at 0x10..0x13
      '{1,0,1,0,1,0,0,1,4'hF,0,6'h10,36'h111111111,0,36'h0,4'd1},
      '{1,1,0,0,1,0,0,1,4'hF,0,6'h00,36'h222222222,0,36'h0,4'd4},
      '{1,1,0,0,1,0,0,1,4'hF,0,6'h00,36'h333333333,0,36'h0,4'd4},
      '{1,1,0,0,1,0,0,1,4'hF,0,6'h00,36'h444444444,0,36'h0,4'd4},
      '{1,0,1,0,0,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd10},
      // R6: processor start with global write low is still a read
      '{0,1,1,0,1,0,0,1,4'hF,0,6'h12,36'hFFFFFFFFF,0,36'h0,4'd6},
      '{1,1,0,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h333333333,4'd6},
      // R2: linear order from low bits 2 -> 3,0,1
      '{1,1,0,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h444444444,4'd2},
      '{1,1,0,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h111111111,4'd2},
      '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h222222222,4'd2},
      // R10: deselect at this edge cuts the drive
      '{1,0,1,0,0,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd10},
      // R3: interleaved order from low bits 1 -> 0,3,2
      '{0,1,1,0,1,0,1,1,4'hF,1,6'h11,36'h0,0,36'h0,4'd3},
      '{1,1,0,0,1,0,1,1,4'hF,1,6'h00,36'h0,1,36'h222222222,4'd3},
      '{1,1,0,0,1,0,1,1,4'hF,1,6'h00,36'h0,1,36'h111111111,4'd3},
      '{1,1,0,0,1,0,1,1,4'hF,1,6'h00,36'h0,1,36'h444444444,4'd3},
      '{1,1,1,0,1,0,1,1,4'hF,1,6'h00,36'h0,1,36'h333333333,4'd3},
      '{1,0,1,0,0,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd10},
      // R8: lanes 0 and 2 written, then bwrite_n high blocks all lanes
      '{1,0,1,0,1,0,1,0,4'b1010,0,6'h12,36'hFFFFFFFFF,0,36'h0,4'd8},
      '{1,1,1,0,1,0,1,1,4'b0000,0,6'h00,36'hAAAAAAAAA,0,36'h0,4'd8},
      '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h337FF33FF,4'd8},
      '{1,0,1,0,0,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd10},
      // R7: global write overrides byte controls
      '{1,0,1,0,1,0,0,0,4'b1110,0,6'h13,36'h987654321,0,36'h0,4'd7},
      '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd7},
      '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h987654321,4'd7},
      '{1,0,1,0,0,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd10},
      // R5: processor strobe with sel0_n high does nothing
      '{0,1,1,1,1,0,1,1,4'hF,0,6'h10,36'h0,0,36'h0,4'd5},
      '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd5},
      // R9 R10: select edge, drive two edges later; gated processor strobe
      '{1,0,1,0,1,0,1,1,4'hF,0,6'h10,36'h0,0,36'h0,4'd10},
      '{0,1,0,1,1,0,1,1,4'hF,0,6'h30,36'h0,1,36'h111111111,4'd9},
      '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,1,36'h222222222,4'd5},
      '{1,0,1,0,0,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd10}
   };

   task automatic chk(input bit ok, input int rq, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // Drive one cycle's inputs at the falling edge, sample 5 ns after the
   // next rising edge.
   task automatic step(input vec_t v);
      @(negedge clk);
      proc_strobe_n = v.p;  ctrl_strobe_n = v.c; adv_n = v.a;
      sel0_n = v.s0;        sel1 = v.s1;         sel2_n = v.s2;
      gwrite_n = v.gw;      bwrite_n = v.bw;     lane_we_n = v.ln;
      interleave = v.il;    addr = v.ad;         wdata = v.wd;
      @(posedge clk);
      #5;
   endtask

   localparam vec_t V_PLAIN = '{1,1,1,0,1,0,1,1,4'hF,0,6'h00,36'h0,0,36'h0,4'd0};

   initial begin
      vec_t v;
      repeat (3) @(posedge clk);
      #5;
      // R13: reset state
      chk(drive == 1'b0, 13, {35'd0, drive}, 36'd0, "drive during reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      chk(drive == 1'b0, 13, {35'd0, drive}, 36'd0, "drive after reset");

      for (int i = 0; i < NV; i++) begin
         step(VEC[i]);
         chk(drive == VEC[i].dv, VEC[i].rq, {35'd0, drive}, {35'd0, VEC[i].dv},
             $sformatf("row %0d drive", i));
         if (VEC[i].dv) begin
            chk(rdata == VEC[i].rd, VEC[i].rq, rdata, VEC[i].rd,
                $sformatf("row %0d rdata", i));
         end
      end

      // R11: asynchronous output enable
      v = V_PLAIN; v.c = 1'b0; v.ad = 6'h13;
      step(v);
      step(V_PLAIN);
      chk(drive == 1'b1 && rdata == 36'h987654321, 11, rdata, 36'h987654321,
          "read before oe test");
      oe_n = 1'b1;
      #1;
      chk(drive == 1'b0, 11, {35'd0, drive}, 36'd0, "oe_n high, no clock");
      oe_n = 1'b0;
      #1;
      chk(drive == 1'b1, 11, {35'd0, drive}, 36'd1, "oe_n low again");

      // R12: sleep blocks a write and holds the burst position
      v = V_PLAIN; v.c = 1'b0; v.ad = 6'h11;
      step(v);
      step(V_PLAIN);
      chk(drive == 1'b1 && rdata == 36'h222222222, 12, rdata, 36'h222222222,
          "read before sleep");
      sleep = 1'b1;
      v = V_PLAIN; v.gw = 1'b0; v.a = 1'b0; v.wd = 36'hFFFFFFFFF;
      step(v);
      chk(drive == 1'b0, 12, {35'd0, drive}, 36'd0, "drive in sleep");
      sleep = 1'b0;
      step(V_PLAIN);
      chk(drive == 1'b0, 12, {35'd0, drive}, 36'd0, "first cycle after sleep");
      step(V_PLAIN);
      chk(drive == 1'b1 && rdata == 36'h222222222, 12, rdata, 36'h222222222,
          "same word, unchanged, after sleep");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R13 watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule